// File: doc/BRIEF.md
# I2C Control Register Slave

This block receives write transfers on a two-wire I2C bus and keeps a bank of ten 8-bit control registers. Those registers set up an audio processing chain. The registers cover:

- input attenuation
- surround and effect setup
- phase resistors
- bass
- middle and treble
- left and right speaker levels
- left and right record levels
- input and record-out selection

A fast system clock samples SCL and SDA. Every decision is taken on the synchronized edges of those two lines.

A transfer has this shape:

1. A START.
2. A device address byte, whose lowest bit is the direction. One address bit follows a strap input.
3. A subaddress byte.
4. Any number of data bytes.
5. A STOP.

Bit 7 of the subaddress chooses how data bytes are placed:

- When bit 7 is clear, every data byte lands in the same register.
- When bit 7 is set, a 4-bit pointer steps through the register space after each byte. It wraps from 15 to 0. Bytes aimed at the six unused positions are dropped.

The block pulls SDA low through an open-drain enable to acknowledge. All registers are visible in parallel at the output.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset, registers 0 to 9 hold 0x3F, 0x06, 0x00, 0x07, 0x77, 0x7F, 0x7F, 0x7F, 0x7F, 0x03 in that order. Register k appears on `regs_o[8k+7:8k]`, and `sda_oe` is 0.
- R2: The block acknowledges only the address byte 0x80 when `addr_strap` is 0, and only 0x82 when `addr_strap` is 1. Any other address gets no acknowledge. After such an address, the following bytes get no acknowledge and write nothing until the next START.
- R3: The acknowledge works as follows:
  - `sda_oe` goes to 1 at the SCL falling edge that ends the eighth bit of an acknowledged byte.
  - It stays at 1 through the ninth SCL high phase.
  - It returns to 0 at the following SCL falling edge.
  - It is 0 at all other times.
- R4: An address byte whose direction bit (bit 0) is 1 is not acknowledged, even when its upper seven bits match.
- R5: If subaddress bit 7 is 0, each data byte until STOP or START is written into the register chosen by subaddress bits 3:0. The last byte stays in that register.
- R6: If subaddress bit 7 is 1, the first data byte goes to the chosen register and each later byte goes to the next pointer value.
- R7: In auto-increment mode, a byte whose pointer is 10 to 15 changes no register but is still acknowledged. The pointer wraps from 15 to 0.
- R8: A repeated START, including one after a non-matching address, restarts address reception.
- R9: Subaddress bits 6:4 have no effect on the register chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_strap | input | 1 | Selects address bit 1 (0 gives 0x80, 1 gives 0x82) |
| sda_oe | output | 1 | Open-drain pull-low enable for SDA |
| regs_o | output | 80 | All ten registers, register k on bits 8k+7:8k |

## Verification
Addresses are tried with both strap levels:

- the matching value
- the other strap's value
- the read-direction value
- an unrelated value

Together these show that only the exact write address for the present strap is acknowledged. A run of bytes to one fixed subaddress is checked against an auto-increment run that crosses register 9. This separates overwrite from stepping, and shows the drop-but-acknowledge behaviour at 10.

A run starting at 14 must wrap to register 0. A subaddress with bits 6:4 set must reach the same register as without them. Repeated STARTs placed after a good transfer and after a rejected address show that the block restarts address reception.

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter int NREG   = 10,
  parameter int PTRW   = 4,
  parameter logic [5:0] ADDR_HI = 6'b100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic [8*NREG-1:0] regs_o
);
  typedef enum logic [2:0] {IDLE, ADDR, SUB, DATA, SKIP} st_t;

  function automatic logic [7:0] dflt(int k);
    case (k)
      0: return 8'h3F;
      1: return 8'h06;
      2: return 8'h00;
      3: return 8'h07;
      4: return 8'h77;
      9: return 8'h03;
      default: return 8'h7F;
    endcase
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  wire        scl_s = scl_sy[1];
  wire        sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;

  st_t             st;
  logic [3:0]      bitcnt;
  logic [7:0]      sh;
  logic            in_ack, inc;
  logic [PTRW-1:0] ptr;
  logic [7:0]      regs [NREG];

  wire [7:0] my_addr = {ADDR_HI, addr_strap, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; bitcnt <= '0; sh <= '0; in_ack <= 1'b0; inc <= 1'b0;
      ptr <= '0; sda_oe <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= dflt(k);
    end else if (start) begin
      st <= ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (st != IDLE && st != SKIP) begin
      if (scl_rise && bitcnt != 4'd8) begin
        sh     <= {sh[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0;
        end else if (bitcnt == 4'd8) begin
          case (st)
            ADDR:
              if (sh == my_addr) begin
                in_ack <= 1'b1; sda_oe <= 1'b1; st <= SUB;
              end else st <= SKIP;
            SUB: begin
              ptr <= sh[PTRW-1:0]; inc <= sh[7];
              in_ack <= 1'b1; sda_oe <= 1'b1; st <= DATA;
            end
            DATA: begin
              for (int k = 0; k < NREG; k++)
                if (ptr == PTRW'(k)) regs[k] <= sh;
              if (inc) ptr <= ptr + 1'b1;
              in_ack <= 1'b1; sda_oe <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[8*g +: 8] = regs[g];
  end

  p_oe_rise_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  p_oe_fall_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(scl_fall) || $past(start) || $past(stop)));
  p_oe_hold_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && scl_s && !start && !stop) |=> sda_oe);
  p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SKIP) |-> !sda_oe);
  p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != DATA) |=> $stable(regs_o));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sda_oe && st == ADDR));
endmodule

// File: tb/i2c_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module i2c_ctrl_regs_tb_top;
  localparam int Q = 10;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, strap = 0;
  logic sda_oe;
  logic [79:0] regs_o;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_ctrl_regs dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                       .addr_strap(strap), .sda_oe(sda_oe), .regs_o(regs_o));

  int checks = 0, errors = 0;
  logic [7:0] model [10];
  logic exp_q [$];
  string tag_q [$];
  logic obs;
  event ack_ev;
  bit done = 0;

  task automatic tk(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(logic ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial forever begin
    logic e; string t;
    @(ack_ev);
    e = exp_q.pop_front(); t = tag_q.pop_front();
    chk(obs === e, t, "ack", int'(obs), int'(e));
  end

  task automatic i2c_start;
    sda_m = 1; tk(Q); scl = 1; tk(Q); sda_m = 0; tk(Q); scl = 0; tk(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; tk(Q); scl = 1; tk(Q); sda_m = 1; tk(Q);
  endtask

  task automatic send(logic [7:0] b, logic exp, string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tk(Q); scl = 1; tk(2*Q); scl = 0; tk(Q);
    end
    exp_q.push_back(exp); tag_q.push_back(tag);
    sda_m = 1; tk(Q); scl = 1; tk(Q); obs = sda_oe; ->ack_ev;
    tk(Q); scl = 0; tk(Q);
    chk(sda_oe == 1'b0, "R3", "oe after ninth clock", int'(sda_oe), 0);
  endtask

  task automatic check_regs(string tag);
    for (int k = 0; k < 10; k++)
      chk(regs_o[8*k +: 8] === model[k], tag, $sformatf("reg%0d", k),
          int'(regs_o[8*k +: 8]), int'(model[k]));
  endtask

  initial begin
    model = '{8'h3F, 8'h06, 8'h00, 8'h07, 8'h77, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h03};
    tk(5); rst_n = 1; tk(5);
    check_regs("R1");
    chk(sda_oe == 1'b0, "R1", "oe at reset", int'(sda_oe), 0);

    // R5 single byte and overwrite
    i2c_start; send(8'h80, 1, "R2"); send(8'h03, 1, "R5"); send(8'h55, 1, "R5");
    i2c_stop; model[3] = 8'h55; check_regs("R5");
    i2c_start; send(8'h80, 1, "R2"); send(8'h01, 1, "R5");
    send(8'h11, 1, "R5"); send(8'h22, 1, "R5"); send(8'h33, 1, "R5");
    i2c_stop; model[1] = 8'h33; check_regs("R5");

    // R6 increment across register 9, R7 drop at 10 with ack
    i2c_start; send(8'h80, 1, "R2"); send(8'h87, 1, "R6");
    send(8'h01, 1, "R6"); send(8'h02, 1, "R6"); send(8'h03, 1, "R6");
    send(8'h04, 1, "R7");
    i2c_stop; model[7] = 8'h01; model[8] = 8'h02; model[9] = 8'h03;
    check_regs("R6");

    // R7 wrap 14,15 -> 0
    i2c_start; send(8'h80, 1, "R2"); send(8'h8E, 1, "R7");
    send(8'hA1, 1, "R7"); send(8'hB2, 1, "R7"); send(8'hC3, 1, "R7");
    send(8'hD4, 1, "R7");
    i2c_stop; model[0] = 8'hC3; model[1] = 8'hD4; check_regs("R7");

    // R9 don't-care bits
    i2c_start; send(8'h80, 1, "R2"); send(8'h72, 1, "R9"); send(8'h99, 1, "R9");
    i2c_stop; model[2] = 8'h99; check_regs("R9");

    // R2 mismatch ignored
    i2c_start; send(8'h82, 0, "R2"); send(8'h04, 0, "R2"); send(8'h12, 0, "R2");
    i2c_stop; check_regs("R2");

    // R4 read direction
    i2c_start; send(8'h81, 0, "R4"); send(8'h04, 0, "R4"); i2c_stop;
    check_regs("R4");

    // R2 strap high
    strap = 1; tk(Q);
    i2c_start; send(8'h80, 0, "R2"); send(8'h04, 0, "R2"); i2c_stop;
    i2c_start; send(8'h83, 0, "R4"); i2c_stop;
    i2c_start; send(8'h82, 1, "R2"); send(8'h04, 1, "R2"); send(8'h44, 1, "R2");
    i2c_stop; model[4] = 8'h44; check_regs("R2");
    strap = 0; tk(Q);

    // R8 repeated START after good and after rejected address
    i2c_start; send(8'h80, 1, "R8"); send(8'h05, 1, "R8"); send(8'h5A, 1, "R8");
    i2c_start; send(8'h80, 1, "R8"); send(8'h06, 1, "R8"); send(8'h6B, 1, "R8");
    i2c_start; send(8'h84, 0, "R8");
    i2c_start; send(8'h80, 1, "R8"); send(8'h08, 1, "R8"); send(8'h88, 1, "R8");
    i2c_stop; model[5] = 8'h5A; model[6] = 8'h6B; model[8] = 8'h88;
    check_regs("R8");

    tk(Q);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule